// File: doc/BRIEF.md
# Interrupt Rate Limiter

This block sits on the path from an interrupt-raising device to a processor interrupt input. Deliveries to the processor are spaced by at least a programmable number of clock cycles. After each delivery a hold-off down counter is loaded from the `interval` input, and no further interrupt passes until that counter has drained to zero. A request that cannot be passed on at once is parked in a single pending bit. Later requests that arrive while the bit is occupied are lost. The effect is a hard ceiling on the interrupt load that a misbehaving or hostile device can impose.

`dev_req` is a one-cycle request strobe. `irq` is a level output that the processor clears with a one-cycle `cpu_ack`. Two enables, one global and one for this source, must both be high for a delivery to happen. A request made while delivery is blocked only by the enables is held in the pending bit until the enables allow it.

Top module: `irq_rate_gate`

## Requirements
- R1: After reset, `irq` is low, the pending bit is clear and the hold-off counter is zero. A request in the first cycle after reset is therefore delivered on the next clock edge, and no second delivery follows it.
- R2: A delivery raises `irq` on the clock edge that ends the cycle in which it is decided, and loads the hold-off counter with the value present on `interval` in that cycle.
- R3: While nonzero and not being reloaded, the hold-off counter decreases by one per clock edge and stops at zero. Two deliveries are therefore at least `interval`+1 edges apart. With `interval` = 0, deliveries may occur on consecutive edges.
- R4: A request that arrives while the counter is nonzero, or while either enable is low, is not delivered. It sets the pending bit if that bit is clear.
- R5: The pending bit holds one interrupt. A request is discarded if it arrives while the bit is set, or in the same cycle as the pending interrupt is delivered.
- R6: A delivery requires `glb_en` = 1 and `src_en` = 1. A request parked while an enable was low is delivered in the first cycle in which both enables are high and the counter is zero.
- R7: A pending interrupt is delivered in the first cycle in which the counter reads zero. That delivery clears the pending bit and restarts the interval.
- R8: A request that arrives in a cycle in which the counter reads zero, with both enables high, is delivered directly and leaves the pending bit clear.
- R9: `irq` stays high until a cycle with `cpu_ack` = 1, and drops on the edge that ends that cycle. If a delivery falls in the same cycle as an acknowledge, the delivery wins and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dev_req | input | 1 | One-cycle interrupt request strobe from the device |
| cpu_ack | input | 1 | One-cycle acknowledge from the processor; clears `irq` |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 1 | Enable for this source |
| interval | input | CNT_W | Minimum spacing reload value, in clock cycles |
| irq | output | 1 | Level interrupt request to the processor |

## Verification
A corrupted counter shows up as a delivery that comes earlier or later than `interval`+1 edges after the previous one. It becomes visible the first time a parked request waits on the counter. A pending bit stuck high produces an `irq` that nobody requested, one interval after an acknowledge. A pending bit stuck low loses a parked request, so `irq` never rises even though the counter has drained. Because `irq` is visible one edge after each decision, each of these faults appears at the ports within one interval of its cause, and the directed scenarios use short windows around every delivery.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned DEF_CNT_W = 8;

  typedef struct packed {
    logic fire;   // deliver to the processor this cycle
    logic take;   // delivery consumes the pending interrupt
    logic park;   // request stored in the pending bit
  } gate_dec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_holdoff_cnt.sv
module irq_holdoff_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_zero
);
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_zero = (cnt == '0);
    cnt_en   = reload | ~cnt_zero;
    cnt_nxt  = reload ? reload_val : (cnt - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_en;
  logic q_nxt;

  always_comb begin
    q_en  = set | clr;
    q_nxt = set;          // set wins over a simultaneous clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/irq_rate_gate.sv
module irq_rate_gate
  import irq_gate_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             cpu_ack,
  input  logic             glb_en,
  input  logic             src_en,
  input  logic [CNT_W-1:0] interval,
  output logic             irq
);
  logic             rst_n_sync;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             pend;
  logic             ready;
  gate_dec_t        dec;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    ready    = cnt_zero & glb_en & src_en;
    dec.fire = ready & (dev_req | pend);
    dec.take = dec.fire & pend;
    dec.park = dev_req & ~dec.fire & ~pend;
  end

  irq_holdoff_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .reload     (dec.fire),
    .reload_val (interval),
    .cnt        (cnt),
    .cnt_zero   (cnt_zero)
  );

  irq_flag_reg u_pend (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .set   (dec.park),
    .clr   (dec.take),
    .q     (pend)
  );

  irq_flag_reg u_irq (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .set   (dec.fire),
    .clr   (cpu_ack),
    .q     (irq)
  );
endmodule

// File: rtl/irq_rate_gate_chk.sv
module irq_rate_gate_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_req,
  input logic             cpu_ack,
  input logic             glb_en,
  input logic             src_en,
  input logic [CNT_W-1:0] interval,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             fire
);
  logic [CNT_W:0]   gap;
  logic [CNT_W-1:0] last_iv;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      last_iv <= '0;
      seen    <= 1'b0;
    end else if (fire) begin
      gap     <= '0;
      last_iv <= interval;
      seen    <= 1'b1;
    end else if (gap != {(CNT_W+1){1'b1}}) begin
      gap     <= gap + 1'b1;
    end
  end

  AST_RELOAD_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == $past(interval)));                                   // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));                 // R3
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen) |-> (gap >= {1'b0, last_iv}));                         // R3
  AST_PARK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && cnt != '0) |=> pend);                                     // R4
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !fire) |=> pend);                                            // R5
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en || !src_en) |=> !$rose(irq));                                // R6
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !fire) |=> !irq);                                         // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cpu_ack) |=> irq);                                           // R9
endmodule

bind irq_rate_gate irq_rate_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .dev_req  (dev_req),
  .cpu_ack  (cpu_ack),
  .glb_en   (glb_en),
  .src_en   (src_en),
  .interval (interval),
  .irq      (irq),
  .cnt      (cnt),
  .pend     (pend),
  .fire     (dec.fire)
);

// File: tb/irq_rate_gate_tb.sv
module irq_rate_gate_tb;
  localparam int CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             dev_req;
  logic             cpu_ack;
  logic             glb_en;
  logic             src_en;
  logic [CNT_W-1:0] interval;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  irq_rate_gate #(.CNT_W(CNT_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req),
    .cpu_ack  (cpu_ack),
    .glb_en   (glb_en),
    .src_en   (src_en),
    .interval (interval),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 50000)", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive inputs, pass the rising edge, sample 2 ns later.
  task automatic cyc(input logic r, input logic a);
    dev_req = r;
    cpu_ack = a;
    @(posedge clk);
    #2;
    dev_req = 1'b0;
    cpu_ack = 1'b0;
  endtask

  // Idle n cycles; returns 1 if irq ever went high.
  task automatic idle(input int n, output int rose);
    rose = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0);
      if (irq) rose = 1;
    end
  endtask

  // Count edges until irq is seen high (limit 300).
  task automatic wait_rise(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      cyc(1'b0, 1'b0);
      n++;
      if (irq) break;
    end
  endtask

  // Acknowledge, then let the counter drain.
  task automatic settle();
    int r;
    cyc(1'b0, 1'b1);
    idle(int'(interval) + 2, r);
  endtask

  task automatic t_reset();
    int r;
    rst_n = 1'b0;
    dev_req = 1'b0; cpu_ack = 1'b0; glb_en = 1'b1; src_en = 1'b1;
    interval = 8'd4;
    repeat (3) @(posedge clk);
    #2;
    check("R1 irq low in reset", irq, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 irq low after reset", irq, 0);
    cyc(1'b1, 1'b0);
    check("R1 counter zero: first request delivered", irq, 1);
    cyc(1'b0, 1'b1);
    idle(8, r);
    check("R1 pending clear: no extra delivery", r, 0);
  endtask

  task automatic t_hold_and_ack();
    cyc(1'b1, 1'b0);
    check("R2 delivery on next edge", irq, 1);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    check("R9 irq held without ack", irq, 1);
    cyc(1'b0, 1'b1);
    check("R9 ack clears irq", irq, 0);
    settle();
  endtask

  task automatic t_spacing(input int iv);
    int n;
    interval = iv[CNT_W-1:0];
    cyc(1'b1, 1'b0);
    check("R2 direct delivery", irq, 1);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    check("R4 request during hold-off not delivered", irq, 0);
    wait_rise(n);
    check("R7 R3 pending delivered at interval+1", n, iv - 1);
    settle();
  endtask

  task automatic t_drop();
    int n;
    int r;
    interval = 8'd4;
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    wait_rise(n);
    check("R5 single pending delivered", n, 1);
    cyc(1'b0, 1'b1);
    idle(12, r);
    check("R5 extra requests discarded", r, 0);
  endtask

  task automatic t_zero_same_cycle();
    int r;
    interval = 8'd4;
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    check("R8 request at counter zero delivered directly", irq, 1);
    cyc(1'b0, 1'b1);
    idle(12, r);
    check("R8 pending not set by direct delivery", r, 0);
  endtask

  task automatic t_enables();
    int r;
    interval = 8'd3;
    glb_en = 1'b0;
    cyc(1'b1, 1'b0);
    idle(5, r);
    check("R6 global enable low blocks delivery", r | int'(irq), 0);
    glb_en = 1'b1;
    cyc(1'b0, 1'b0);
    check("R6 parked request delivered on enable", irq, 1);
    settle();
    src_en = 1'b0;
    cyc(1'b1, 1'b0);
    idle(5, r);
    check("R6 source enable low blocks delivery", r | int'(irq), 0);
    src_en = 1'b1;
    cyc(1'b0, 1'b0);
    check("R6 parked request delivered on source enable", irq, 1);
    settle();
  endtask

  task automatic t_zero_interval();
    interval = 8'd0;
    cyc(1'b1, 1'b0);
    check("R3 interval 0 first delivery", irq, 1);
    cyc(1'b1, 1'b1);
    check("R9 delivery wins over ack, R3 back-to-back", irq, 1);
    cyc(1'b0, 1'b1);
    check("R9 ack clears irq", irq, 0);
    settle();
  endtask

  initial begin
    t_reset();
    t_hold_and_ack();
    t_spacing(4);
    t_spacing(9);
    t_drop();
    t_zero_same_cycle();
    t_enables();
    t_zero_interval();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule